// File: doc/BRIEF.md
# Serial Receive Idle Timeout Timer

This block watches a serial receive path for an idle gap, so that software can find where a variable-length frame ends. It counts down a programmable 16-bit timeout. It decrements once per received bit period, given as a one-cycle tick. Each received character reloads the count. When the count runs out, a sticky timeout flag is raised. That flag, gated by an enable input, drives a registered interrupt request.

Software has two command strobes. The arm command loads the timeout and freezes the countdown until the next character arrives, so that line idle before a frame never causes a timeout. The retrigger command loads the timeout and starts counting at once, which gives periodic timeouts while the line stays quiet. A timeout value of zero switches detection off. The live count is brought out for debug.

The reset input is asynchronous and active low. Its release is synchronised inside the block over two clock edges.

Top module: `rx_idle_timer`

## Requirements
- R1: While `timeout_val` is 0, the next edge forces `count` to 0 and `timeout_flag` to 0. Characters, ticks and commands have no effect. Once the value is nonzero again, the block waits for a character before it counts.
- R2: In the running state, `count` decreases by exactly one on each cycle where `bit_tick` is 1. It is unchanged on every other cycle.
- R3: When `char_rx` is 1 with a nonzero timeout, `count` is loaded with `timeout_val` on the next edge and the countdown runs.
- R4: The tick that takes `count` from 1 to 0 sets `timeout_flag`. After that, `count` stays at 0 until a character or a command reloads it.
- R5: `timeout_flag` is sticky. A received character does not clear it. Either command strobe clears it on the next edge.
- R6: `cmd_arm` loads `timeout_val` and freezes the count. Ticks are then ignored until the next `char_rx`.
- R7: `cmd_retrig` loads `timeout_val` and starts decrementing on the following ticks, with no character needed. A tick in the same cycle as the strobe does not decrement.
- R8: When strobes coincide, `cmd_retrig` takes priority over `cmd_arm`, and `cmd_arm` takes priority over `char_rx`.
- R9: After reset, `count`, `timeout_flag` and `irq` are 0 and the block is frozen, waiting for a character.
- R10: `irq` equals `timeout_flag AND irq_en` as they stood one clock earlier.
- R11: A change to `timeout_val` while the counter runs does not alter `count` until the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per receive bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| timeout_val | input | 16 | Timeout length in bit periods; 0 disables |
| cmd_arm | input | 1 | Strobe: load and wait for next character |
| cmd_retrig | input | 1 | Strobe: load and count immediately |
| irq_en | input | 1 | Interrupt enable |
| timeout_flag | output | 1 | Sticky timeout status |
| irq | output | 1 | Registered interrupt request |
| count | output | 16 | Live counter value |

## Verification
The bench targets the expiry edge. A design that went on decrementing past zero, or that re-set the flag, would show a wrapped count or no hold at 0. It drives coincident strobes. A wrong priority would leave the counter frozen where it should run, or the reverse. It also checks that a received character leaves a set flag alone, that ticks are ignored while armed, and that a timeout value changed mid-count is picked up only at the next reload. A design that loaded the new value too early would show the new value instead of the decremented old one. Switching the value to zero with the flag set must clear the flag and park the counter.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    MODE_WAIT = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_DONE = 2'd2
  } mode_t;
endpackage

// File: rtl/rxto_rst_sync.sv
module rxto_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import rxto_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dis,
  input  logic  retrig,
  input  logic  arm,
  input  logic  char_rx,
  input  logic  tick,
  input  logic  count_one,
  input  logic  count_zero,
  output logic  load,
  output logic  dec,
  output logic  expire,
  output logic  clear,
  output mode_t mode
);
  mode_t mode_q, mode_d;

  // priority: disable > retrigger > arm > character > tick
  always_comb begin
    load   = !dis && (retrig || arm || char_rx);
    dec    = !dis && !load && (mode_q == MODE_RUN) && tick && !count_zero;
    expire = dec && count_one;
    clear  = dis;
    mode_d = mode_q;
    if (dis)          mode_d = MODE_WAIT;
    else if (retrig)  mode_d = MODE_RUN;
    else if (arm)     mode_d = MODE_WAIT;
    else if (char_rx) mode_d = MODE_RUN;
    else if (expire)  mode_d = MODE_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_WAIT;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  // R6: no decrement while frozen
  p_wait_no_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_WAIT) |-> !dec);
  // R7: retrigger with a live value leaves the block running
  p_retrig_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retrig && !dis) |=> (mode_q == MODE_RUN));
  // R8: arm beats a coincident character
  p_arm_beats_char_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && char_rx && !retrig && !dis) |=> (mode_q == MODE_WAIT));
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             count_one,
  output logic             count_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear || load || dec;
    if (clear)     cnt_d = '0;
    else if (load) cnt_d = load_val;
    else           cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count      = cnt_q;
  assign count_one  = (cnt_q == ONE);
  assign count_zero = (cnt_q == '0);

  // R2: without a load the count moves by at most one step down
  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !clear) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (clr)      flag_d = 1'b0;
    else if (set) flag_d = 1'b1;
    irq_d = flag_q && irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;

  // R5: flag holds unless cleared
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R10: interrupt follows gated flag one clock later
  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == $past(flag_q && irq_en)));
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             char_rx,
  input  logic [CNT_W-1:0] timeout_val,
  input  logic             cmd_arm,
  input  logic             cmd_retrig,
  input  logic             irq_en,
  output logic             timeout_flag,
  output logic             irq,
  output logic [CNT_W-1:0] count
);
  import rxto_pkg::*;

  localparam int RST_STAGES = 2;

  logic  rst_sync_n;
  logic  dis, load, dec, expire, clear, count_one, count_zero;
  mode_t mode;

  assign dis = (timeout_val == '0);

  rxto_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxto_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .dis        (dis),
    .retrig     (cmd_retrig),
    .arm        (cmd_arm),
    .char_rx    (char_rx),
    .tick       (bit_tick),
    .count_one  (count_one),
    .count_zero (count_zero),
    .load       (load),
    .dec        (dec),
    .expire     (expire),
    .clear      (clear),
    .mode       (mode)
  );

  rxto_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clear      (clear),
    .load       (load),
    .dec        (dec),
    .load_val   (timeout_val),
    .count      (count),
    .count_one  (count_one),
    .count_zero (count_zero)
  );

  rxto_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set    (expire),
    .clr    (dis || cmd_arm || cmd_retrig),
    .irq_en (irq_en),
    .flag   (timeout_flag),
    .irq    (irq)
  );

  // R1: zero value parks the counter and clears the flag
  p_disabled_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dis |=> (count == '0) && !timeout_flag);
  // R3: a character with a live value reloads the count
  p_char_reload_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (char_rx && !dis) |=> (count == $past(timeout_val)));
  // R4: zero count holds without a reload source
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count == '0 && !char_rx && !cmd_arm && !cmd_retrig) |=> (count == '0));
  // R5: either command clears the flag
  p_cmd_clears_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_arm || cmd_retrig) |=> !timeout_flag);
endmodule

// File: tb/test_rx_idle_timer.sv
module test_rx_idle_timer;
  localparam time TCLK = 20ns;

  typedef struct packed {
    logic        rt;
    logic        ar;
    logic        ch;
    logic        tk;
    logic [15:0] val;
    logic [15:0] cnt;
    logic        flg;
  } vec_t;

  localparam int NV = 36;
  // fields: retrig, arm, char, tick, timeout value, expected count, expected flag
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd0,1'b0}, // 0  R9 frozen out of reset
    '{1'b0,1'b0,1'b1,1'b0,16'd3,16'd3,1'b0}, // 1  R3
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd2,1'b0}, // 2  R2
    '{1'b0,1'b0,1'b0,1'b0,16'd3,16'd2,1'b0}, // 3  R2 no tick
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd1,1'b0}, // 4  R2
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd0,1'b1}, // 5  R4 expiry
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd0,1'b1}, // 6  R4 hold
    '{1'b0,1'b0,1'b1,1'b0,16'd3,16'd3,1'b1}, // 7  R5 char keeps flag
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd2,1'b1}, // 8  R5
    '{1'b0,1'b1,1'b0,1'b0,16'd3,16'd3,1'b0}, // 9  R6 arm
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd3,1'b0}, // 10 R6 frozen
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd3,1'b0}, // 11 R6 frozen
    '{1'b0,1'b0,1'b1,1'b0,16'd3,16'd3,1'b0}, // 12 R6 char resumes
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd2,1'b0}, // 13 R6
    '{1'b1,1'b0,1'b0,1'b0,16'd3,16'd3,1'b0}, // 14 R7
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd2,1'b0}, // 15 R7
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd1,1'b0}, // 16 R7
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd0,1'b1}, // 17 R7 periodic expiry
    '{1'b1,1'b0,1'b0,1'b1,16'd3,16'd3,1'b0}, // 18 R7 tick with strobe ignored
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd2,1'b0}, // 19 R7
    '{1'b1,1'b1,1'b1,1'b0,16'd3,16'd3,1'b0}, // 20 R8 all strobes
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd2,1'b0}, // 21 R8 retrig won
    '{1'b0,1'b1,1'b1,1'b0,16'd3,16'd3,1'b0}, // 22 R8 arm + char
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd3,1'b0}, // 23 R8 arm won
    '{1'b0,1'b0,1'b1,1'b0,16'd3,16'd3,1'b0}, // 24 R11
    '{1'b0,1'b0,1'b0,1'b1,16'd5,16'd2,1'b0}, // 25 R11 new value not used
    '{1'b0,1'b0,1'b1,1'b0,16'd5,16'd5,1'b0}, // 26 R11 picked up on reload
    '{1'b0,1'b0,1'b0,1'b1,16'd0,16'd0,1'b0}, // 27 R1
    '{1'b0,1'b0,1'b1,1'b0,16'd0,16'd0,1'b0}, // 28 R1
    '{1'b1,1'b0,1'b0,1'b0,16'd0,16'd0,1'b0}, // 29 R1
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd0,1'b0}, // 30 R1 waits for char
    '{1'b0,1'b0,1'b1,1'b0,16'd3,16'd3,1'b0}, // 31 R3
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd2,1'b0}, // 32
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd1,1'b0}, // 33
    '{1'b0,1'b0,1'b0,1'b1,16'd3,16'd0,1'b1}, // 34 R4
    '{1'b0,1'b0,1'b0,1'b0,16'd0,16'd0,1'b0}  // 35 R1 clears set flag
  };

  logic        clk, rst_n, bit_tick, char_rx, cmd_arm, cmd_retrig, irq_en;
  logic [15:0] timeout_val, count;
  logic        timeout_flag, irq;
  int          checks, errors;
  bit          done;

  rx_idle_timer i_rx_idle_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .char_rx      (char_rx),
    .timeout_val  (timeout_val),
    .cmd_arm      (cmd_arm),
    .cmd_retrig   (cmd_retrig),
    .irq_en       (irq_en),
    .timeout_flag (timeout_flag),
    .irq          (irq),
    .count        (count)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic drive(input logic rt, ar, ch, tk, input logic [15:0] val);
    cmd_retrig = rt; cmd_arm = ar; char_rx = ch; bit_tick = tk; timeout_val = val;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    irq_en = 1'b0;
    do_reset();
    chk("R9 count", count, 16'd0);
    chk("R9 flag", {15'd0, timeout_flag}, 16'd0);
    chk("R9 irq", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rt, VEC[i].ar, VEC[i].ch, VEC[i].tk, VEC[i].val);
      step();
      chk($sformatf("vector %0d count", i), count, VEC[i].cnt);
      chk($sformatf("vector %0d flag", i), {15'd0, timeout_flag}, {15'd0, VEC[i].flg});
    end

    // R10: interrupt timing and gating
    drive(1'b0, 1'b0, 1'b1, 1'b0, 16'd2); irq_en = 1'b1; step();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'd2); step();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'd2); step();
    chk("R4 flag at expiry", {15'd0, timeout_flag}, 16'd1);
    chk("R10 irq not yet", {15'd0, irq}, 16'd0);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 16'd2); step();
    chk("R10 irq raised", {15'd0, irq}, 16'd1);
    irq_en = 1'b0; step();
    chk("R10 irq gated off", {15'd0, irq}, 16'd0);
    chk("R5 flag still set", {15'd0, timeout_flag}, 16'd1);

    // R9: reset in the middle of a count
    drive(1'b0, 1'b0, 1'b1, 1'b0, 16'd7); step();
    do_reset();
    chk("R9 count after mid reset", count, 16'd0);
    chk("R9 flag after mid reset", {15'd0, timeout_flag}, 16'd0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 16'd7); step();
    chk("R9 frozen after reset", count, 16'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(TCLK * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule